// File: doc/BRIEF.md
# Floating-Point Rounding Selector and Sticky Exception Flags

This block sits beside a floating-point datapath and does the bookkeeping that surrounds each arithmetic operation. It takes the three-bit rounding field carried by an instruction and turns it into the rounding mode the datapath should use. The field either names a mode directly or defers to a mode value held in a small programmable register. Encodings that name no mode, whether they appear directly or in the register, mark the instruction as illegal.

The block also holds the accrued exception flags. When an operation completes without a fault, its exception bits are merged into the flags and stay set. A faulting operation leaves the flags untouched, and the block withholds the writeback enable for its destination register. Software can overwrite, set bits in or clear bits in the flag register through a simple write port, and it can load the dynamic mode register. Both registers can be read directly at the outputs.

Top module: `fp_rmode_flags`

## Requirements
- R1: A rounding field of 0, 1, 2, 3 or 4 (nearest-even, toward zero, downward, upward, nearest with ties away from zero) appears unchanged on `eff_mode`, and `illegal` stays low. This is combinational from the inputs.
- R2: A rounding field of 7 puts the dynamic mode register's value on `eff_mode` when that value is in the range 0 to 4, and `illegal` stays low.
- R3: A rounding field of 5 or 6 drives `illegal` high, `wb_en` low and `eff_mode` to 0.
- R4: A rounding field of 7 while the dynamic mode register holds 5, 6 or 7 drives `illegal` high, `wb_en` low and `eff_mode` to 0.
- R5: Flag bits are inexact at bit 0, underflow at bit 1, overflow at bit 2, divide-by-zero at bit 3 and invalid at bit 4. A valid, non-faulting operation ORs `exc_bits` into `flags` at the next clock edge and never clears a bit that is already set.
- R6: A valid operation that is illegal leaves `flags` unchanged.
- R7: `wb_en` is high exactly when `op_valid` is high and `illegal` is low. While `op_valid` is low, `exc_bits` has no effect on `flags`.
- R8: When `sw_flags_we` is high, `sw_flags_op` selects the action taken at the next edge: 0 replaces `flags` with `sw_flags_wdata`, 1 sets the bits that are 1 in the data, 2 clears the bits that are 1 in the data, and 3 leaves `flags` unchanged.
- R9: A software flag access in the same cycle as a valid, non-faulting operation takes priority, and that operation's exception bits are dropped.
- R10: When `sw_mode_we` is high, `dyn_mode` takes any 3-bit `sw_mode_wdata` value, including the illegal values, at the next edge. The value is held until the next write.
- R11: A synchronous active-high reset clears `flags` and sets `dyn_mode` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rm_field | input | 3 | Rounding field of the current instruction |
| op_valid | input | 1 | An operation completes this cycle |
| exc_bits | input | 5 | Exception bits produced by that operation |
| sw_flags_we | input | 1 | Software flag access strobe |
| sw_flags_op | input | 2 | Software flag action: 0 write, 1 set, 2 clear, 3 none |
| sw_flags_wdata | input | 5 | Data or mask for the software flag action |
| sw_mode_we | input | 1 | Software write strobe for the dynamic mode register |
| sw_mode_wdata | input | 3 | New dynamic mode value |
| eff_mode | output | 3 | Resolved rounding mode, 0 when illegal |
| illegal | output | 1 | The instruction's rounding encoding is illegal |
| wb_en | output | 1 | The destination register may be written |
| flags | output | 5 | Accrued sticky exception flags |
| dyn_mode | output | 3 | Current dynamic mode register value |

## Verification
The bench loads the dynamic register with each of 5, 6 and 7 and then issues field 7. A resolver that checks only the static field would pass those modes through as legal and let their exception bits leak into the flags. Faulting operations carry all five exception bits, so a design that accumulates before checking legality shows a changed flag word. Same-cycle collisions between software accesses and accumulation are driven for the write, set and no-op actions. A wrong priority either keeps or loses the operation's bits. A final reset from a dirty state confirms that both registers return to zero.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  localparam int RM_W   = 3;
  localparam int FLAG_W = 5;

  // rounding codes; behaviour depends on these values
  localparam int RM_MAX_LEGAL = 4;
  localparam int RM_DYN_CODE  = 7;

  // flag bit positions
  localparam int FLG_INEXACT  = 0;
  localparam int FLG_UNDER    = 1;
  localparam int FLG_OVER     = 2;
  localparam int FLG_DIVZERO  = 3;
  localparam int FLG_INVALID  = 4;

  typedef enum logic [1:0] {
    FOP_WRITE = 2'd0,
    FOP_SET   = 2'd1,
    FOP_CLEAR = 2'd2,
    FOP_NONE  = 2'd3
  } flag_op_e;
endpackage

// File: rtl/rmf_mode_resolve.sv
module rmf_mode_resolve #(
  parameter int RM_W      = rmf_pkg::RM_W,
  parameter int MAX_LEGAL = rmf_pkg::RM_MAX_LEGAL,
  parameter int DYN_CODE  = rmf_pkg::RM_DYN_CODE
) (
  input  logic [RM_W-1:0] field_i,
  input  logic [RM_W-1:0] dyn_i,
  output logic [RM_W-1:0] mode_o,
  output logic            bad_o
);
  localparam logic [RM_W-1:0] DynSel   = RM_W'(DYN_CODE);
  localparam logic [RM_W-1:0] LegalTop = RM_W'(MAX_LEGAL);

  logic [RM_W-1:0] picked;

  always_comb begin
    // the dynamic selector indirects once; a dynamic value of DYN_CODE is illegal
    picked = (field_i == DynSel) ? dyn_i : field_i;
    bad_o  = (picked > LegalTop);
    mode_o = bad_o ? '0 : picked;
  end
endmodule

// File: rtl/rmf_mode_reg.sv
module rmf_mode_reg #(
  parameter int RM_W = rmf_pkg::RM_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [RM_W-1:0] wdata_i,
  output logic [RM_W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst)       mode_q <= '0;
    else if (we_i) mode_q <= wdata_i;
  end
endmodule

// File: rtl/rmf_flag_acc.sv
module rmf_flag_acc #(
  parameter int FLAG_W = rmf_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en_i,
  input  logic [FLAG_W-1:0] acc_bits_i,
  input  logic              sw_we_i,
  input  logic [1:0]        sw_op_i,
  input  logic [FLAG_W-1:0] sw_data_i,
  output logic [FLAG_W-1:0] flags_q
);
  import rmf_pkg::*;

  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    if (sw_we_i) begin
      // software access wins over accumulation
      case (sw_op_i)
        FOP_WRITE: flags_d = sw_data_i;
        FOP_SET:   flags_d = flags_q | sw_data_i;
        FOP_CLEAR: flags_d = flags_q & ~sw_data_i;
        default:   flags_d = flags_q;
      endcase
    end else if (acc_en_i) begin
      flags_d = flags_q | acc_bits_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/fp_rmode_flags.sv
module fp_rmode_flags #(
  parameter int RM_W      = rmf_pkg::RM_W,
  parameter int FLAG_W    = rmf_pkg::FLAG_W,
  parameter int MAX_LEGAL = rmf_pkg::RM_MAX_LEGAL,
  parameter int DYN_CODE  = rmf_pkg::RM_DYN_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RM_W-1:0]   rm_field,
  input  logic              op_valid,
  input  logic [FLAG_W-1:0] exc_bits,
  input  logic              sw_flags_we,
  input  logic [1:0]        sw_flags_op,
  input  logic [FLAG_W-1:0] sw_flags_wdata,
  input  logic              sw_mode_we,
  input  logic [RM_W-1:0]   sw_mode_wdata,
  output logic [RM_W-1:0]   eff_mode,
  output logic              illegal,
  output logic              wb_en,
  output logic [FLAG_W-1:0] flags,
  output logic [RM_W-1:0]   dyn_mode
);
  import rmf_pkg::*;

  localparam logic [RM_W-1:0] LegalTop = RM_W'(MAX_LEGAL);

  logic commit;

  rmf_mode_reg #(.RM_W(RM_W)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .we_i    (sw_mode_we),
    .wdata_i (sw_mode_wdata),
    .mode_q  (dyn_mode)
  );

  rmf_mode_resolve #(
    .RM_W(RM_W), .MAX_LEGAL(MAX_LEGAL), .DYN_CODE(DYN_CODE)
  ) u_res (
    .field_i (rm_field),
    .dyn_i   (dyn_mode),
    .mode_o  (eff_mode),
    .bad_o   (illegal)
  );

  assign commit = op_valid & ~illegal;
  assign wb_en  = commit;

  rmf_flag_acc #(.FLAG_W(FLAG_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .acc_en_i   (commit),
    .acc_bits_i (exc_bits),
    .sw_we_i    (sw_flags_we),
    .sw_op_i    (sw_flags_op),
    .sw_data_i  (sw_flags_wdata),
    .flags_q    (flags)
  );

  // resolver outputs against the raw instruction field
  assert_static_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (rm_field <= LegalTop) |-> (eff_mode == rm_field && !illegal));

  assert_reserved_field_R3: assert property (@(posedge clk) disable iff (rst)
    (rm_field == RM_W'(5) || rm_field == RM_W'(6)) |-> (illegal && !wb_en && eff_mode == '0));

  // flag register behaviour over time
  assert_sticky_merge_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !illegal && !sw_flags_we) |=>
      (((flags & $past(flags)) == $past(flags)) && ((flags & $past(exc_bits)) == $past(exc_bits))));

  assert_fault_no_update_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && illegal && !sw_flags_we) |=> $stable(flags));

  assert_idle_no_update_R7: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !sw_flags_we) |=> $stable(flags));

  assert_sw_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (sw_flags_we && sw_flags_op == FOP_WRITE) |=> (flags == $past(sw_flags_wdata)));

  assert_mode_load_R10: assert property (@(posedge clk) disable iff (rst)
    sw_mode_we |=> (dyn_mode == $past(sw_mode_wdata)));
endmodule

// File: tb/fp_rmode_flags_tb.sv
module fp_rmode_flags_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rm_field = '0;
  logic       op_valid = 1'b0;
  logic [4:0] exc_bits = '0;
  logic       sw_flags_we = 1'b0;
  logic [1:0] sw_flags_op = '0;
  logic [4:0] sw_flags_wdata = '0;
  logic       sw_mode_we = 1'b0;
  logic [2:0] sw_mode_wdata = '0;
  logic [2:0] eff_mode;
  logic       illegal;
  logic       wb_en;
  logic [4:0] flags;
  logic [2:0] dyn_mode;

  always #4 clk = ~clk;

  fp_rmode_flags u_dut (
    .clk(clk), .rst(rst), .rm_field(rm_field), .op_valid(op_valid),
    .exc_bits(exc_bits), .sw_flags_we(sw_flags_we), .sw_flags_op(sw_flags_op),
    .sw_flags_wdata(sw_flags_wdata), .sw_mode_we(sw_mode_we),
    .sw_mode_wdata(sw_mode_wdata), .eff_mode(eff_mode), .illegal(illegal),
    .wb_en(wb_en), .flags(flags), .dyn_mode(dyn_mode)
  );

  typedef struct packed {
    logic [2:0] eff;
    logic       ill;
    logic       wb;
    logic [4:0] flg;
    logic [2:0] dyn;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  logic [4:0] m_flags = '0;
  logic [2:0] m_dyn = '0;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outcome
  task automatic step(input logic [2:0] rm, input logic v, input logic [4:0] ex,
                      input logic fwe, input logic [1:0] fop, input logic [4:0] fwd,
                      input logic mwe, input logic [2:0] mwd, input string tag);
    exp_t e;
    logic [2:0] res;
    @(negedge clk);
    rm_field = rm; op_valid = v; exc_bits = ex;
    sw_flags_we = fwe; sw_flags_op = fop; sw_flags_wdata = fwd;
    sw_mode_we = mwe; sw_mode_wdata = mwd;
    res   = (rm == 3'd7) ? m_dyn : rm;
    e.ill = (res > 3'd4);
    e.eff = e.ill ? 3'd0 : res;
    e.wb  = v & ~e.ill;
    if (fwe) begin
      case (fop)
        2'd0: m_flags = fwd;
        2'd1: m_flags = m_flags | fwd;
        2'd2: m_flags = m_flags & ~fwd;
        default: m_flags = m_flags;
      endcase
    end else if (e.wb) begin
      m_flags = m_flags | ex;
    end
    if (mwe) m_dyn = mwd;
    e.flg = m_flags;
    e.dyn = m_dyn;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    rm_field = '0; op_valid = 1'b0; exc_bits = '0;
    sw_flags_we = 1'b0; sw_flags_op = '0; sw_flags_wdata = '0;
    sw_mode_we = 1'b0; sw_mode_wdata = '0;
  endtask

  // monitor: combinational outputs mid-cycle, registers after the edge
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(negedge clk); #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "eff_mode", 8'(eff_mode), 8'(e.eff));
        chk(t, "illegal",  8'(illegal),  8'(e.ill));
        chk(t, "wb_en",    8'(wb_en),    8'(e.wb));
        @(posedge clk); #2;
        chk(t, "flags",    8'(flags),    8'(e.flg));
        chk(t, "dyn_mode", 8'(dyn_mode), 8'(e.dyn));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #2;
    chk("R11", "flags after reset", 8'(flags), 8'h00);
    chk("R11", "dyn after reset", 8'(dyn_mode), 8'h00);

    // R1 and R5: static modes, one flag bit per operation
    for (int i = 0; i < 5; i++)
      step(3'(i), 1'b1, 5'(1 << i), 1'b0, 2'd0, 5'd0, 1'b0, 3'd0, "R1_R5");
    // R5: an operation with no exceptions keeps all set bits
    step(3'd2, 1'b1, 5'd0, 1'b0, 2'd0, 5'd0, 1'b0, 3'd0, "R5");
    // R8: clear everything
    step(3'd0, 1'b0, 5'd0, 1'b1, 2'd2, 5'h1f, 1'b0, 3'd0, "R8");
    // R3 and R6: reserved static fields with every exception bit raised
    step(3'd5, 1'b1, 5'h1f, 1'b0, 2'd0, 5'd0, 1'b0, 3'd0, "R3_R6");
    step(3'd6, 1'b1, 5'h1f, 1'b0, 2'd0, 5'd0, 1'b0, 3'd0, "R3_R6");
    // R10 and R2: dynamic selection of each legal mode
    for (int m = 0; m < 5; m++) begin
      step(3'd0, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 1'b1, 3'(m), "R10");
      step(3'd7, 1'b1, 5'(1 << m), 1'b0, 2'd0, 5'd0, 1'b0, 3'd0, "R2");
    end
    step(3'd0, 1'b0, 5'd0, 1'b1, 2'd0, 5'd0, 1'b0, 3'd0, "R8");
    // R4: dynamic register holding 5, 6, 7
    for (int m = 5; m < 8; m++) begin
      step(3'd1, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 1'b1, 3'(m), "R10");
      step(3'd7, 1'b1, 5'h1f, 1'b0, 2'd0, 5'd0, 1'b0, 3'd0, "R4_R6");
      step(3'd3, 1'b1, 5'h04, 1'b0, 2'd0, 5'd0, 1'b0, 3'd0, "R1");
    end
    // R7: no valid strobe, exceptions present
    step(3'd0, 1'b0, 5'h1b, 1'b0, 2'd0, 5'd0, 1'b0, 3'd0, "R7");
    // R8: set, clear, no-op, write
    step(3'd0, 1'b0, 5'd0, 1'b1, 2'd1, 5'h06, 1'b0, 3'd0, "R8");
    step(3'd0, 1'b0, 5'd0, 1'b1, 2'd2, 5'h02, 1'b0, 3'd0, "R8");
    step(3'd0, 1'b0, 5'd0, 1'b1, 2'd3, 5'h1f, 1'b0, 3'd0, "R8");
    step(3'd0, 1'b0, 5'd0, 1'b1, 2'd0, 5'h15, 1'b0, 3'd0, "R8");
    // R9: software access colliding with a legal operation
    step(3'd1, 1'b1, 5'h0a, 1'b1, 2'd0, 5'h01, 1'b0, 3'd0, "R9");
    step(3'd1, 1'b1, 5'h10, 1'b1, 2'd1, 5'h02, 1'b0, 3'd0, "R9");
    step(3'd1, 1'b1, 5'h1c, 1'b1, 2'd3, 5'h00, 1'b0, 3'd0, "R9");
    step(3'd4, 1'b1, 5'h10, 1'b0, 2'd0, 5'd0, 1'b0, 3'd0, "R5");
    idle();
    repeat (3) @(posedge clk);
    while (exp_q.size() > 0) @(posedge clk);

    // R11: reset from a dirty state
    step(3'd0, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 1'b1, 3'd6, "R10");
    idle();
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    chk("R11", "flags after late reset", 8'(flags), 8'h00);
    chk("R11", "dyn after late reset", 8'(dyn_mode), 8'h00);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule